// File: doc/BRIEF.md
# Register-Mapped Serial Port with Single-Byte Buffers

This block is a plain asynchronous serial port that sits on a small word-addressed register bus. Software writes a byte to the data register. The byte waits in a one-byte transmit holding buffer until the shifter is free, and then leaves on `txd` as a fixed frame: one start bit, eight data bits sent least significant bit first, and one stop bit. There is no parity and no choice of frame format. The receiver follows `rxd`, rebuilds each frame and places the byte in a one-byte receive holding buffer. Software collects the byte by reading the data register.

The bit period is set by a divisor register that counts system clocks per bit. Transmit and receive each have their own enable bit and their own interrupt-enable bit. Each direction also detects overrun and has a separate enable for its overrun interrupt. Latched interrupt flags drive a transmit line, a receive line, an overrun line and a combined line. Software clears a flag by writing one to its bit.

Top module: `suart_top`

## Requirements
- R1: After reset, STATE (0x04), CTRL (0x08) and INT (0x0C) read 0 and BAUDDIV (0x10) reads 16. `txd` is high and all four interrupt outputs are low.
- R2: A write to DATA (0x00) while CTRL bit 0 (transmit enable) is set sends a frame on `txd`. The frame is a low start bit, the eight data bits least significant bit first, and a high stop bit. Each bit lasts the effective divisor in clocks.
- R3: When CTRL bit 1 (receive enable) is set, a valid frame on `rxd` loads the byte and sets STATE bit 1 (receive full). A read of DATA returns the byte and clears STATE bit 1.
- R4: A DATA write while STATE bit 0 (transmit full) is set discards the new byte, keeps the held byte and sets STATE bit 2 (transmit overrun).
- R5: A byte that completes while STATE bit 1 is set is discarded and sets STATE bit 3 (receive overrun). The first byte stays readable. STATE bits 2 and 3 clear only on reset or on a write of 1 to that bit at STATE.
- R6: A write to INT clears each flag whose bit is written as 1 and leaves a flag alone when its bit is written as 0. If a flag is set and cleared in the same cycle, the set wins.
- R7: INT bit 0 is set when the held byte moves into the shifter, but only while CTRL bit 2 is set. `irq_tx` equals INT bit 0.
- R8: INT bit 1 is set when a received byte is loaded into the buffer, but only while CTRL bit 3 is set. `irq_rx` equals INT bit 1.
- R9: INT bit 2 is set on a transmit overrun while CTRL bit 4 is set. INT bit 3 is set on a receive overrun while CTRL bit 5 is set. `irq_ovr` is the OR of INT bits 2 and 3, and `irq_any` is the OR of all four INT bits.
- R10: While CTRL bit 0 is clear, `txd` stays high, no frame starts and a written byte waits in the buffer.
- R11: While CTRL bit 1 is clear, the receiver ignores `rxd` and loads no byte.
- R12: BAUDDIV keeps bits 20:0 of the written word and reads back only those bits. A value below 16 acts as 16 for bit timing.
- R13: A falling edge on `rxd` starts a frame only if the line is still low half a bit period later. A shorter low pulse is ignored. Each data bit is sampled one full bit period after the previous sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| txd | output | 1 | Serial transmit line, idles high |
| rxd | input | 1 | Serial receive line, asynchronous |
| irq_tx | output | 1 | Transmit interrupt flag |
| irq_rx | output | 1 | Receive interrupt flag |
| irq_ovr | output | 1 | Either overrun interrupt flag |
| irq_any | output | 1 | Any interrupt flag |

## Verification
The assertions check on every cycle the invariants that follow from local state:
- a disabled transmitter holds `txd` high on the next cycle;
- a disabled receiver returns to idle;
- the transmit-full flag drops only when the shifter takes the byte;
- the sticky overrun bits and the latched interrupt flags never drop without a matching clear;
- the effective divisor never falls below 16.

Only the bench's scenarios can show the end-to-end behaviour:
- the bit order and bit length seen on `txd`;
- that a byte sent on `rxd` is reassembled correctly;
- which byte survives an overrun in each direction;
- that a short glitch is rejected as a false start;
- that register reads return the masked divisor and the right flag bits.

// File: rtl/suart_pkg.sv
package suart_pkg;
    localparam int BUS_W      = 32;
    localparam int ADDR_W     = 5;
    localparam int DIV_W      = 21;
    localparam int MIN_DIV    = 16;
    localparam int BYTE_W     = 8;
    localparam int N_FLAG     = 4;
    localparam int CTRL_W     = 6;

    localparam logic [ADDR_W-1:0] OFF_DATA  = 5'h00;
    localparam logic [ADDR_W-1:0] OFF_STATE = 5'h04;
    localparam logic [ADDR_W-1:0] OFF_CTRL  = 5'h08;
    localparam logic [ADDR_W-1:0] OFF_INT   = 5'h0C;
    localparam logic [ADDR_W-1:0] OFF_BAUD  = 5'h10;

    // Flag positions shared by STATE (overrun part) and INT
    localparam int F_TX    = 0;
    localparam int F_RX    = 1;
    localparam int F_TXOVR = 2;
    localparam int F_RXOVR = 3;

    // Control word, bit 0 at the bottom
    typedef struct packed {
        logic rxovr_ie;
        logic txovr_ie;
        logic rx_ie;
        logic tx_ie;
        logic rx_on;
        logic tx_on;
    } ctrl_t;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_e;

    function automatic logic [DIV_W-1:0] floor_div(input logic [DIV_W-1:0] raw);
        return (raw < DIV_W'(MIN_DIV)) ? DIV_W'(MIN_DIV) : raw;
    endfunction
endpackage

// File: rtl/suart_tx.sv
module suart_tx
    import suart_pkg::*;
#(
    parameter int DW = DIV_W,
    parameter int BW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [DW-1:0] div,
    input  logic          wr,
    input  logic [BW-1:0] wr_byte,
    output logic          full,
    output logic          moved,
    output logic          ovr,
    output logic          txd
);
    localparam int CNT_W = $clog2(BW + 2);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BW + 1);

    logic [BW-1:0]    hold;
    logic             busy;
    logic [BW:0]      shreg;
    logic [CNT_W-1:0] bitno;
    logic [DW-1:0]    cyc;

    assign moved = en && !busy && full;
    assign ovr   = wr && full;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold  <= '0;
            full  <= 1'b0;
            busy  <= 1'b0;
            shreg <= '1;
            bitno <= '0;
            cyc   <= '0;
            txd   <= 1'b1;
        end else begin
            if (moved)
                full <= 1'b0;
            if (wr && !full) begin
                hold <= wr_byte;
                full <= 1'b1;
            end

            if (!en) begin
                busy <= 1'b0;
                txd  <= 1'b1;
            end else if (moved) begin
                busy  <= 1'b1;
                txd   <= 1'b0;
                shreg <= {1'b1, hold};
                bitno <= '0;
                cyc   <= '0;
            end else if (busy) begin
                if (cyc == div - DW'(1)) begin
                    cyc <= '0;
                    if (bitno == LAST_BIT) begin
                        busy <= 1'b0;
                    end else begin
                        txd   <= shreg[0];
                        shreg <= {1'b1, shreg[BW:1]};
                        bitno <= bitno + CNT_W'(1);
                    end
                end else begin
                    cyc <= cyc + DW'(1);
                end
            end
        end
    end

    p_txd_idle_off_r10: assert property (@(posedge clk) disable iff (rst)
        !en |=> txd);

    p_full_drop_by_load_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(full) |-> $past(en && !busy));
endmodule

// File: rtl/suart_rx.sv
module suart_rx
    import suart_pkg::*;
#(
    parameter int DW = DIV_W,
    parameter int BW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [DW-1:0] div,
    input  logic          rxd,
    input  logic          rd,
    output logic [BW-1:0] data,
    output logic          full,
    output logic          got,
    output logic          ovr
);
    localparam int IDX_W = $clog2(BW);
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(BW - 1);

    logic          s1, s2, prev;
    rx_state_e     st;
    logic [DW-1:0] cyc;
    logic [IDX_W-1:0] idx;
    logic [BW-1:0] sh;
    logic [DW-1:0] half;
    logic          fall;

    assign half = div >> 1;
    assign fall = prev && !s2;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1   <= 1'b1;
            s2   <= 1'b1;
            prev <= 1'b1;
        end else begin
            s1   <= rxd;
            s2   <= s1;
            prev <= s2;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= RX_IDLE;
            cyc  <= '0;
            idx  <= '0;
            sh   <= '0;
            data <= '0;
            full <= 1'b0;
            got  <= 1'b0;
            ovr  <= 1'b0;
        end else begin
            got <= 1'b0;
            ovr <= 1'b0;
            if (rd)
                full <= 1'b0;

            if (!en) begin
                st <= RX_IDLE;
            end else begin
                unique case (st)
                    RX_IDLE: begin
                        if (fall) begin
                            st  <= RX_START;
                            cyc <= '0;
                        end
                    end
                    RX_START: begin
                        if (cyc == half - DW'(1)) begin
                            cyc <= '0;
                            idx <= '0;
                            st  <= s2 ? RX_IDLE : RX_DATA;
                        end else begin
                            cyc <= cyc + DW'(1);
                        end
                    end
                    RX_DATA: begin
                        if (cyc == div - DW'(1)) begin
                            cyc <= '0;
                            sh  <= {s2, sh[BW-1:1]};
                            if (idx == TOP_IDX)
                                st <= RX_STOP;
                            else
                                idx <= idx + IDX_W'(1);
                        end else begin
                            cyc <= cyc + DW'(1);
                        end
                    end
                    RX_STOP: begin
                        if (cyc == div - DW'(1)) begin
                            st <= RX_IDLE;
                            if (s2) begin
                                if (full) begin
                                    ovr <= 1'b1;
                                end else begin
                                    data <= sh;
                                    full <= 1'b1;
                                    got  <= 1'b1;
                                end
                            end
                        end else begin
                            cyc <= cyc + DW'(1);
                        end
                    end
                    default: st <= RX_IDLE;
                endcase
            end
        end
    end

    p_rx_idle_off_r11: assert property (@(posedge clk) disable iff (rst)
        !en |=> (st == RX_IDLE));

    p_rx_load_needs_room_r5: assert property (@(posedge clk) disable iff (rst)
        got |-> !$past(full));
endmodule

// File: rtl/suart_irq.sv
module suart_irq
    import suart_pkg::*;
#(
    parameter int NF = N_FLAG
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NF-1:0] set,
    input  logic [NF-1:0] clr,
    output logic [NF-1:0] flags
);
    for (genvar i = 0; i < NF; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                flags[i] <= 1'b0;
            else if (set[i])
                flags[i] <= 1'b1;
            else if (clr[i])
                flags[i] <= 1'b0;
        end

        p_flag_hold_r6: assert property (@(posedge clk) disable iff (rst)
            (flags[i] && !clr[i]) |=> flags[i]);
    end
endmodule

// File: rtl/suart_top.sv
module suart_top
    import suart_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = BUS_W,
    parameter int VW = DIV_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_en,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          txd,
    input  logic          rxd,
    output logic          irq_tx,
    output logic          irq_rx,
    output logic          irq_ovr,
    output logic          irq_any
);
    ctrl_t          ctrl;
    logic [VW-1:0]  baud;
    logic [VW-1:0]  eff_div;
    logic           tx_ovr_st, rx_ovr_st;
    logic           wr, rd_data;
    logic [N_FLAG-1:0] int_set, int_clr, int_flags, state_clr;
    logic           tx_full, tx_moved, tx_ovr;
    logic           rx_full, rx_got, rx_ovr;
    logic [BYTE_W-1:0] rx_byte;
    logic           unused_hi;

    assign unused_hi = ^bus_wdata[DW-1:VW];

    assign wr        = bus_en && bus_we;
    assign rd_data   = bus_en && !bus_we && (bus_addr == OFF_DATA);
    assign eff_div   = floor_div(baud);
    assign state_clr = (wr && bus_addr == OFF_STATE) ? bus_wdata[N_FLAG-1:0] : '0;
    assign int_clr   = (wr && bus_addr == OFF_INT) ? bus_wdata[N_FLAG-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl      <= '0;
            baud      <= VW'(MIN_DIV);
            tx_ovr_st <= 1'b0;
            rx_ovr_st <= 1'b0;
        end else begin
            if (wr && bus_addr == OFF_CTRL)
                ctrl <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
            if (wr && bus_addr == OFF_BAUD)
                baud <= bus_wdata[VW-1:0];
            if (tx_ovr)
                tx_ovr_st <= 1'b1;
            else if (state_clr[F_TXOVR])
                tx_ovr_st <= 1'b0;
            if (rx_ovr)
                rx_ovr_st <= 1'b1;
            else if (state_clr[F_RXOVR])
                rx_ovr_st <= 1'b0;
        end
    end

    suart_tx #(.DW(VW), .BW(BYTE_W)) u_tx (
        .clk     (clk),
        .rst     (rst),
        .en      (ctrl.tx_on),
        .div     (eff_div),
        .wr      (wr && bus_addr == OFF_DATA),
        .wr_byte (bus_wdata[BYTE_W-1:0]),
        .full    (tx_full),
        .moved   (tx_moved),
        .ovr     (tx_ovr),
        .txd     (txd)
    );

    suart_rx #(.DW(VW), .BW(BYTE_W)) u_rx (
        .clk  (clk),
        .rst  (rst),
        .en   (ctrl.rx_on),
        .div  (eff_div),
        .rxd  (rxd),
        .rd   (rd_data),
        .data (rx_byte),
        .full (rx_full),
        .got  (rx_got),
        .ovr  (rx_ovr)
    );

    always_comb begin
        int_set          = '0;
        int_set[F_TX]    = tx_moved && ctrl.tx_ie;
        int_set[F_RX]    = rx_got   && ctrl.rx_ie;
        int_set[F_TXOVR] = tx_ovr   && ctrl.txovr_ie;
        int_set[F_RXOVR] = rx_ovr   && ctrl.rxovr_ie;
    end

    suart_irq #(.NF(N_FLAG)) u_irq (
        .clk   (clk),
        .rst   (rst),
        .set   (int_set),
        .clr   (int_clr),
        .flags (int_flags)
    );

    assign irq_tx  = int_flags[F_TX];
    assign irq_rx  = int_flags[F_RX];
    assign irq_ovr = int_flags[F_TXOVR] | int_flags[F_RXOVR];
    assign irq_any = |int_flags;

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFF_DATA:  bus_rdata[BYTE_W-1:0] = rx_byte;
            OFF_STATE: bus_rdata[N_FLAG-1:0] = {rx_ovr_st, tx_ovr_st, rx_full, tx_full};
            OFF_CTRL:  bus_rdata[CTRL_W-1:0] = ctrl;
            OFF_INT:   bus_rdata[N_FLAG-1:0] = int_flags;
            OFF_BAUD:  bus_rdata[VW-1:0]     = baud;
            default:   bus_rdata = '0;
        endcase
    end

    p_rxovr_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        ($past(rx_ovr_st) && !$past(state_clr[F_RXOVR])) |-> rx_ovr_st);

    p_txovr_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        ($past(tx_ovr_st) && !$past(state_clr[F_TXOVR])) |-> tx_ovr_st);

    p_div_floor_r12: assert property (@(posedge clk) disable iff (rst)
        eff_div >= VW'(MIN_DIV));
endmodule

// File: tb/suart_top_test.sv
module suart_top_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        txd;
    logic        rxd = 1'b1;
    logic        irq_tx, irq_rx, irq_ovr, irq_any;

    int n_checks = 0;
    int n_errors = 0;

    // {byte sent on txd, byte sent into rxd}
    localparam logic [15:0] VEC [0:5] = '{
        16'h00_FF, 16'hFF_00, 16'hA5_5A, 16'h01_80, 16'h3C_C3, 16'h7E_81
    };

    always #5 clk = ~clk;

    suart_top uut (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .txd(txd), .rxd(rxd), .irq_tx(irq_tx), .irq_rx(irq_rx),
        .irq_ovr(irq_ovr), .irq_any(irq_any)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_en = 1'b0;
    endtask

    task automatic capture(input int div, output logic [7:0] b);
        int t = 0;
        b = 'x;
        while (txd !== 1'b0 && t < 5000) begin @(negedge clk); t++; end
        if (t >= 5000) begin
            chk("R2 frame start", 32'(txd), 32'h0);
            return;
        end
        repeat (div / 2) @(negedge clk);
        chk("R2 start bit", 32'(txd), 32'h0);
        for (int i = 0; i < 8; i++) begin
            repeat (div) @(negedge clk);
            b[i] = txd;
        end
        repeat (div) @(negedge clk);
        chk("R2 stop bit", 32'(txd), 32'h1);
    endtask

    task automatic start_len(output int n);
        int t = 0;
        n = 0;
        while (txd !== 1'b0 && t < 5000) begin @(negedge clk); t++; end
        while (txd === 1'b0 && n < 5000) begin n++; @(negedge clk); end
    endtask

    task automatic send(input int div, input logic [7:0] b);
        @(negedge clk);
        rxd = 1'b0;
        repeat (div) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            repeat (div) @(negedge clk);
        end
        rxd = 1'b1;
        repeat (div) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        logic [7:0]  b;
        int          n;
        int          lows;

        repeat (5) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(5'h04, d); chk("R1 STATE", d, 32'h0);
        rd(5'h08, d); chk("R1 CTRL", d, 32'h0);
        rd(5'h0C, d); chk("R1 INT", d, 32'h0);
        rd(5'h10, d); chk("R1 BAUDDIV", d, 32'd16);
        chk("R1 txd/irqs", {27'h0, txd, irq_tx, irq_rx, irq_ovr, irq_any}, 32'h10);

        wr(5'h08, 32'h3F);

        // Table walk: R2, R3, R7, R8
        for (int i = 0; i < 6; i++) begin
            wr(5'h00, {24'h0, VEC[i][15:8]});
            capture(16, b);
            chk("R2 tx byte", {24'h0, b}, {24'h0, VEC[i][15:8]});
            rd(5'h0C, d); chk("R7 INT tx flag", d, 32'h1);
            chk("R7 irq_tx", {31'h0, irq_tx}, 32'h1);
            wr(5'h0C, 32'hF);
            send(16, VEC[i][7:0]);
            rd(5'h04, d); chk("R3 rx full", d, 32'h2);
            chk("R8 irq_rx", {31'h0, irq_rx}, 32'h1);
            rd(5'h00, d); chk("R3 rx byte", d, {24'h0, VEC[i][7:0]});
            rd(5'h04, d); chk("R3 rx full cleared", d, 32'h0);
            wr(5'h0C, 32'hF);
        end

        // R6 write-one-to-clear, R9 combined
        wr(5'h00, 32'h42);
        capture(16, b);
        send(16, 8'h24);
        rd(5'h0C, d); chk("R6 both flags", d, 32'h3);
        wr(5'h0C, 32'h0);
        rd(5'h0C, d); chk("R6 zero write keeps", d, 32'h3);
        wr(5'h0C, 32'h1);
        rd(5'h0C, d); chk("R6 clear bit0 only", d, 32'h2);
        chk("R9 irq_any on", {31'h0, irq_any}, 32'h1);
        wr(5'h0C, 32'h2);
        chk("R9 irq_any off", {31'h0, irq_any}, 32'h0);
        rd(5'h00, d);

        // R10 transmitter off, R4 transmit overrun
        wr(5'h08, 32'h3E);
        wr(5'h00, 32'hA5);
        rd(5'h04, d); chk("R10 byte held", d, 32'h1);
        lows = 0;
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            if (txd !== 1'b1) lows++;
        end
        chk("R10 txd idle", 32'(lows), 32'h0);
        wr(5'h00, 32'h5A);
        rd(5'h04, d); chk("R4 tx overrun", d, 32'h5);
        rd(5'h0C, d); chk("R9 INT tx overrun", d, 32'h4);
        chk("R9 irq_ovr", {31'h0, irq_ovr}, 32'h1);
        wr(5'h0C, 32'h4);
        rd(5'h04, d); chk("R4 sticky after INT clear", d & 32'h4, 32'h4);
        wr(5'h08, 32'h3F);
        capture(16, b);
        chk("R4 held byte kept", {24'h0, b}, 32'hA5);
        wr(5'h04, 32'h4);
        rd(5'h04, d); chk("R4 overrun cleared", d, 32'h0);
        wr(5'h0C, 32'hF);

        // R7 gating by interrupt enable
        wr(5'h08, 32'h3B);
        wr(5'h00, 32'h33);
        capture(16, b);
        rd(5'h0C, d); chk("R7 gated off", d, 32'h0);
        wr(5'h08, 32'h3F);

        // R5 receive overrun
        send(16, 8'h11);
        send(16, 8'h22);
        rd(5'h04, d); chk("R5 rx overrun", d, 32'hA);
        rd(5'h0C, d); chk("R9 INT rx overrun", d, 32'hA);
        rd(5'h00, d); chk("R5 first byte kept", d, 32'h11);
        wr(5'h0C, 32'hF);
        rd(5'h04, d); chk("R5 sticky", d, 32'h8);
        wr(5'h04, 32'h8);
        rd(5'h04, d); chk("R5 cleared", d, 32'h0);

        // R11 receiver off
        wr(5'h08, 32'h3D);
        send(16, 8'h77);
        rd(5'h04, d); chk("R11 ignored", d, 32'h0);
        rd(5'h0C, d); chk("R11 no flag", d, 32'h0);
        wr(5'h08, 32'h3F);

        // R13 false start rejected, then a real frame
        @(negedge clk);
        rxd = 1'b0;
        repeat (4) @(negedge clk);
        rxd = 1'b1;
        repeat (200) @(negedge clk);
        rd(5'h04, d); chk("R13 glitch ignored", d, 32'h0);
        send(16, 8'h96);
        rd(5'h00, d); chk("R13 frame after glitch", d, 32'h96);
        wr(5'h0C, 32'hF);

        // R12 divisor
        wr(5'h10, 32'd40);
        rd(5'h10, d); chk("R12 readback", d, 32'd40);
        wr(5'h00, 32'hFF);
        start_len(n);
        chk("R12 bit length 40", 32'(n), 32'd40);
        repeat (500) @(negedge clk);
        wr(5'h00, 32'hC9);
        capture(40, b);
        chk("R12 byte at 40", {24'h0, b}, 32'hC9);
        send(40, 8'h6D);
        rd(5'h00, d); chk("R12 rx at 40", d, 32'h6D);
        wr(5'h10, 32'd5);
        rd(5'h10, d); chk("R12 small readback", d, 32'd5);
        repeat (500) @(negedge clk);
        wr(5'h00, 32'hFF);
        start_len(n);
        chk("R12 floor 16", 32'(n), 32'd16);
        repeat (300) @(negedge clk);
        wr(5'h10, 32'hFFE0_0010);
        rd(5'h10, d); chk("R12 mask", d, 32'h10);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule